// File: doc/BRIEF.md
# Time-Parallel LRU Set Hit/Miss Counter

This block measures how a single four-way cache set behaves under least-recently-used replacement for a stored trace of block numbers. The trace is written through a load port while the block is idle. A start pulse then splits the first `segCount × SEG_LEN` references into equal segments, one per segment engine. Each engine keeps a private LRU stack.

In the first pass every engine begins from an empty stack. All engines step through their own segments in lockstep, one reference per cycle. For every reference an engine records the resulting stack and whether the reference hit. The misses counted this way never fall below the true count, so their sum is published as an upper bound.

Repair rounds follow. In a round, every engine except the first re-seeds from the stored final stack of its predecessor and replays its segment. An engine stops as soon as its new stack equals the stored one for the same reference, because nothing after that point can differ. The rounds repeat until no engine whose stack feeds a successor has changed its final stack. The corrected hit records then give the exact totals. A one-cycle done pulse marks completion and also reports how many repair rounds ran.

Top module: `lru_tps_top`

## Requirements
- R1: A stack holds four slots, index 0 being the most recent. A reference that matches a valid slot moves that block to index 0, and the slots above its old position each move down one place. The set of valid blocks does not change.
- R2: A reference that matches no valid slot is written to index 0 with its valid bit set. Every other slot moves down one place, and the slot at index 3 is lost when all four slots were valid.
- R3: A slot with a clear valid bit never matches, even when it holds the referenced value. An empty stack therefore misses on block 0.
- R4: `missBound` equals the sum of misses when each active segment starts from an empty stack. It is never below `totalMisses`.
- R5: At done, `totalHits` and `totalMisses` equal the counts from one sequential LRU pass over trace addresses 0 to `segCount×SEG_LEN−1` from an empty stack. Segment e occupies addresses e×SEG_LEN to e×SEG_LEN+SEG_LEN−1.
- R6: `fixRounds` counts the repair rounds. A round ends with completion when no engine other than the last active one changed its final stack. With one active segment no round runs (0). The count is below the number of active segments and saturates at NUM_SEG.
- R7: `done` is high for exactly one cycle per run. Totals and `fixRounds` hold their values after done until a new start.
- R8: `loadEn` writes `loadBlk` to trace address `loadAddr` only while idle. Loads and start pulses that arrive during a run have no effect on that run or on the stored trace.
- R9: `segCount` is sampled at start. A value of 0 acts as 1, and a value above NUM_SEG acts as NUM_SEG.
- R10: After reset, `totalHits`, `totalMisses`, `missBound`, `fixRounds` and `done` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadEn | input | 1 | Write one trace entry (idle only) |
| loadAddr | input | 6 | Trace address to write |
| loadBlk | input | 8 | Block number to store |
| start | input | 1 | Begin a run when idle |
| segCount | input | 3 | Number of active segments |
| totalHits | output | 7 | Exact hit count of the last run |
| totalMisses | output | 7 | Exact miss count of the last run |
| missBound | output | 7 | First-pass miss sum, updated when the first pass ends |
| done | output | 1 | One-cycle completion pulse |
| fixRounds | output | 3 | Repair rounds executed |

## Verification
The assertions assume that `rstN` is asserted before the first start. They also assume that `segCount` and the stored trace only matter at the start edge, so the sampled copy is what the run uses. The bench loads each full trace while idle and gives start as a single-cycle pulse. It drives loads and starts during a run only in the case that checks they are ignored. The stimulus covers these cases:
- segment counts of 0, 1, 2, 4 and 7, which exercises the clamp;
- traces of repeated zeros, which exercise empty-slot matching;
- a trace in which one segment's state must ripple through every later segment, which forces the maximum number of rounds.

// File: rtl/lru_tps_pkg.sv
package lru_tps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS1,
    ST_BOUND,
    ST_SEED,
    ST_FIX,
    ST_FINISH
  } lru_state_t;

  // Strobes from control to datapath, at most one group active per cycle.
  typedef struct packed {
    logic clear;       // empty every stack, a run begins
    logic step1;       // first-pass reference for all engines
    logic latchBound;  // capture first-pass miss sum
    logic seed;        // load predecessor final stacks, arm repair
    logic fixStep;     // repair reference for armed engines
    logic finish;      // publish totals and pulse done
  } lru_strobe_t;

endpackage

// File: rtl/lru_tps_engine.sv
module lru_tps_engine #(
  parameter int WAYS  = 4,
  parameter int BLK_W = 8,
  localparam int POS_W = $clog2(WAYS),
  localparam int VC_W  = $clog2(WAYS + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        clear,
  input  logic                        seed,
  input  logic [WAYS-1:0][BLK_W:0]    seedStk,
  input  logic                        step,
  input  logic [BLK_W-1:0]            refBlk,
  output logic [WAYS-1:0][BLK_W:0]    nextStk,
  output logic                        hit
);

  logic [WAYS-1:0][BLK_W:0] curStk;
  logic [POS_W-1:0]         hitPos;
  logic [POS_W-1:0]         shiftLimit;
  logic [WAYS-1:0]          validBits;
  logic [VC_W-1:0]          validCnt;
  logic                     dupFound;

  // Match search: a slot only counts when its valid bit is set.
  always_comb begin
    hit    = 1'b0;
    hitPos = POS_W'(WAYS - 1);
    for (int j = WAYS - 1; j >= 0; j--) begin
      if (curStk[j][BLK_W] && (curStk[j][BLK_W-1:0] == refBlk)) begin
        hit    = 1'b1;
        hitPos = POS_W'(j);
      end
    end
    // A miss shifts the whole stack, dropping the last slot.
    shiftLimit = hit ? hitPos : POS_W'(WAYS - 1);
  end

  always_comb begin
    nextStk[0] = {1'b1, refBlk};
    for (int j = 1; j < WAYS; j++) begin
      nextStk[j] = (POS_W'(j) <= shiftLimit) ? curStk[j-1] : curStk[j];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      curStk <= '0;
    else if (clear) curStk <= '0;
    else if (seed)  curStk <= seedStk;
    else if (step)  curStk <= nextStk;
  end

  always_comb begin
    dupFound = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      validBits[i] = curStk[i][BLK_W];
      for (int j = i + 1; j < WAYS; j++) begin
        if (curStk[i][BLK_W] && curStk[j][BLK_W] &&
            (curStk[i][BLK_W-1:0] == curStk[j][BLK_W-1:0]))
          dupFound = 1'b1;
      end
    end
    validCnt = VC_W'($countones(validBits));
  end

  AST_TOP_IS_REF: assert property (@(posedge clk) disable iff (!rstN)
    (step && !clear && !seed) |=> curStk[0] == {1'b1, $past(refBlk)}); // R1
  AST_NO_DUP_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    !dupFound); // R1
  AST_HIT_KEEPS_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    (step && hit && !clear && !seed) |=> validCnt == $past(validCnt)); // R1
  AST_MISS_GROWS: assert property (@(posedge clk) disable iff (!rstN)
    (step && !hit && !clear && !seed) |=>
      validCnt == (($past(validCnt) == VC_W'(WAYS)) ? VC_W'(WAYS) : $past(validCnt) + 1'b1)); // R2
  AST_EMPTY_NO_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (step && validBits == '0) |-> !hit); // R3

endmodule

// File: rtl/lru_tps_ctrl.sv
module lru_tps_ctrl
  import lru_tps_pkg::*;
#(
  parameter int NUM_SEG = 4,
  parameter int SEG_LEN = 16,
  localparam int IDX_W  = $clog2(SEG_LEN),
  localparam int SEGC_W = $clog2(NUM_SEG + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [SEGC_W-1:0] segCount,
  input  logic              anyRun,
  input  logic              feedChg,
  output lru_strobe_t       stb,
  output logic [IDX_W-1:0]  refIdx,
  output logic [SEGC_W-1:0] segCntQ,
  output logic              busy,
  output logic [SEGC_W-1:0] fixRounds
);

  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(SEG_LEN - 1);
  localparam logic [SEGC_W-1:0] SEG_MAX  = SEGC_W'(NUM_SEG);

  lru_state_t        st, stNext;
  logic [SEGC_W-1:0] segClamp;

  always_comb begin
    if (segCount == '0)          segClamp = SEGC_W'(1);
    else if (segCount > SEG_MAX) segClamp = SEG_MAX;
    else                         segClamp = segCount;
  end

  always_comb begin
    stb    = '0;
    stNext = st;
    unique case (st)
      ST_IDLE: if (start) begin
        stb.clear = 1'b1;
        stNext    = ST_PASS1;
      end
      ST_PASS1: begin
        stb.step1 = 1'b1;
        if (refIdx == LAST_IDX) stNext = ST_BOUND;
      end
      ST_BOUND: begin
        stb.latchBound = 1'b1;
        stNext = (segCntQ == SEGC_W'(1)) ? ST_FINISH : ST_SEED;
      end
      ST_SEED: begin
        stb.seed = 1'b1;
        stNext   = ST_FIX;
      end
      ST_FIX: begin
        if (anyRun) stb.fixStep = 1'b1;
        else        stNext = feedChg ? ST_SEED : ST_FINISH;
      end
      ST_FINISH: begin
        stb.finish = 1'b1;
        stNext     = ST_IDLE;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st        <= ST_IDLE;
      refIdx    <= '0;
      segCntQ   <= SEGC_W'(1);
      fixRounds <= '0;
    end else begin
      st <= stNext;
      if (stb.clear || stb.seed)       refIdx <= '0;
      else if (stb.step1 || stb.fixStep) refIdx <= refIdx + 1'b1;
      if (stb.clear) begin
        segCntQ   <= segClamp;
        fixRounds <= '0;
      end else if (stb.seed && fixRounds != SEG_MAX) begin
        fixRounds <= fixRounds + 1'b1;
      end
    end
  end

  assign busy = (st != ST_IDLE);

  AST_ROUND_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_FINISH) |-> fixRounds < segCntQ); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> segCntQ == $past(segCntQ)); // R8
  AST_SEG_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (segCntQ != '0) && (segCntQ <= SEG_MAX)); // R9

endmodule

// File: rtl/lru_tps_dp.sv
module lru_tps_dp
  import lru_tps_pkg::*;
#(
  parameter int NUM_SEG = 4,
  parameter int SEG_LEN = 16,
  parameter int BLK_W   = 8,
  parameter int WAYS    = 4,
  localparam int DEPTH  = NUM_SEG * SEG_LEN,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int IDX_W  = $clog2(SEG_LEN),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int SEGC_W = $clog2(NUM_SEG + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  lru_strobe_t       stb,
  input  logic [IDX_W-1:0]  refIdx,
  input  logic [SEGC_W-1:0] segCntQ,
  input  logic              busy,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [BLK_W-1:0]  loadBlk,
  output logic              anyRun,
  output logic              feedChg,
  output logic [CNT_W-1:0]  totalHits,
  output logic [CNT_W-1:0]  totalMisses,
  output logic [CNT_W-1:0]  missBound,
  output logic              done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEG_LEN - 1);

  typedef logic [WAYS-1:0][BLK_W:0] stk_t;

  logic [BLK_W-1:0] traceMem [DEPTH];
  stk_t             finalArr [NUM_SEG];
  logic             runArr   [NUM_SEG];
  logic             chgArr   [NUM_SEG];
  logic [IDX_W:0]   hitCntArr[NUM_SEG];
  logic [CNT_W-1:0] hitSum;
  logic [CNT_W-1:0] refTotal;

  always_ff @(posedge clk) begin
    if (loadEn && !busy) traceMem[loadAddr] <= loadBlk;
  end

  for (genvar e = 0; e < NUM_SEG; e++) begin : g_eng
    stk_t             nextStk;
    stk_t             seedStk;
    stk_t             snap [SEG_LEN];
    logic [SEG_LEN-1:0] hitLog;
    logic [BLK_W-1:0] refBlk;
    logic             hit, run, chg, step, same;

    if (e == 0) begin : g_first
      assign seedStk = '0;
    end else begin : g_rest
      assign seedStk = finalArr[e-1];
    end

    assign refBlk = traceMem[ADDR_W'(e * SEG_LEN) + ADDR_W'(refIdx)];
    assign step   = stb.step1 | (stb.fixStep & run);
    assign same   = (nextStk == snap[refIdx]);

    lru_tps_engine #(.WAYS(WAYS), .BLK_W(BLK_W)) u_engine (
      .clk     (clk),
      .rstN    (rstN),
      .clear   (stb.clear),
      .seed    (stb.seed && (e != 0)),
      .seedStk (seedStk),
      .step    (step),
      .refBlk  (refBlk),
      .nextStk (nextStk),
      .hit     (hit)
    );

    // Snapshot and hit record; a matching replay still rewrites its hit bit.
    always_ff @(posedge clk) begin
      if (step) snap[refIdx] <= nextStk;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hitLog <= '0;
        run    <= 1'b0;
        chg    <= 1'b0;
      end else begin
        if (step) hitLog[refIdx] <= hit;
        if (stb.clear) begin
          run <= 1'b0;
          chg <= 1'b0;
        end else if (stb.seed) begin
          run <= (e != 0) && (SEGC_W'(e) < segCntQ);
          chg <= 1'b0;
        end else if (stb.fixStep && run) begin
          if (same || refIdx == LAST_IDX) run <= 1'b0;
          if (!same && refIdx == LAST_IDX) chg <= 1'b1;
        end
      end
    end

    assign finalArr[e]  = snap[SEG_LEN-1];
    assign runArr[e]    = run;
    assign chgArr[e]    = chg && (SEGC_W'(e + 1) < segCntQ);
    assign hitCntArr[e] = (IDX_W + 1)'($countones(hitLog));

    AST_FIRST_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      (e == 0) |-> !run); // R6
  end

  always_comb begin
    anyRun  = 1'b0;
    feedChg = 1'b0;
    hitSum  = '0;
    for (int e = 0; e < NUM_SEG; e++) begin
      anyRun  = anyRun | runArr[e];
      feedChg = feedChg | chgArr[e];
      if (SEGC_W'(e) < segCntQ) hitSum = hitSum + CNT_W'(hitCntArr[e]);
    end
  end

  assign refTotal = CNT_W'(segCntQ) * CNT_W'(SEG_LEN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      totalHits   <= '0;
      totalMisses <= '0;
      missBound   <= '0;
      done        <= 1'b0;
    end else begin
      done <= stb.finish;
      if (stb.latchBound) missBound <= refTotal - hitSum;
      if (stb.finish) begin
        totalHits   <= hitSum;
        totalMisses <= refTotal - hitSum;
      end
    end
  end

  AST_BOUND_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    done |-> totalMisses <= missBound); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_TOTAL_SUM: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (totalHits + totalMisses) == refTotal); // R5

endmodule

// File: rtl/lru_tps_top.sv
module lru_tps_top
  import lru_tps_pkg::*;
#(
  parameter int NUM_SEG = 4,
  parameter int SEG_LEN = 16,
  parameter int BLK_W   = 8,
  parameter int WAYS    = 4,
  localparam int DEPTH  = NUM_SEG * SEG_LEN,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int IDX_W  = $clog2(SEG_LEN),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int SEGC_W = $clog2(NUM_SEG + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [BLK_W-1:0]  loadBlk,
  input  logic              start,
  input  logic [SEGC_W-1:0] segCount,
  output logic [CNT_W-1:0]  totalHits,
  output logic [CNT_W-1:0]  totalMisses,
  output logic [CNT_W-1:0]  missBound,
  output logic              done,
  output logic [SEGC_W-1:0] fixRounds
);

  lru_strobe_t       stb;
  logic [IDX_W-1:0]  refIdx;
  logic [SEGC_W-1:0] segCntQ;
  logic              busy, anyRun, feedChg;

  lru_tps_ctrl #(.NUM_SEG(NUM_SEG), .SEG_LEN(SEG_LEN)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .segCount  (segCount),
    .anyRun    (anyRun),
    .feedChg   (feedChg),
    .stb       (stb),
    .refIdx    (refIdx),
    .segCntQ   (segCntQ),
    .busy      (busy),
    .fixRounds (fixRounds)
  );

  lru_tps_dp #(.NUM_SEG(NUM_SEG), .SEG_LEN(SEG_LEN), .BLK_W(BLK_W), .WAYS(WAYS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .refIdx      (refIdx),
    .segCntQ     (segCntQ),
    .busy        (busy),
    .loadEn      (loadEn),
    .loadAddr    (loadAddr),
    .loadBlk     (loadBlk),
    .anyRun      (anyRun),
    .feedChg     (feedChg),
    .totalHits   (totalHits),
    .totalMisses (totalMisses),
    .missBound   (missBound),
    .done        (done)
  );

endmodule

// File: tb/lru_tps_top_bench.sv
`timescale 1ns/1ps
module lru_tps_top_bench;

  localparam int NSEG  = 4;
  localparam int SLEN  = 16;
  localparam int DEPTH = NSEG * SLEN;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadEn = 1'b0;
  logic [5:0] loadAddr = '0;
  logic [7:0] loadBlk = '0;
  logic       start = 1'b0;
  logic [2:0] segCount = 3'd4;
  logic [6:0] totalHits, totalMisses, missBound;
  logic       done;
  logic [2:0] fixRounds;

  always #2 clk = ~clk;

  lru_tps_top u_lru_tps_top (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadAddr(loadAddr), .loadBlk(loadBlk),
    .start(start), .segCount(segCount), .totalHits(totalHits), .totalMisses(totalMisses),
    .missBound(missBound), .done(done), .fixRounds(fixRounds)
  );

  int errors = 0;
  int checks = 0;
  int tr [DEPTH];
  int ws [4];
  int wn;
  int fin [NSEG][4];
  int finN [NSEG];
  int nf [NSEG][4];
  int nfN [NSEG];
  int expHits, expMiss, expBound, expRounds;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic modelStep(input int b, output bit h);
    int p = -1;
    for (int j = 0; j < wn; j++) if (ws[j] == b && p < 0) p = j;
    if (p >= 0) begin
      for (int j = p; j > 0; j--) ws[j] = ws[j-1];
      h = 1'b1;
    end else begin
      for (int j = (wn < 4 ? wn : 3); j > 0; j--) ws[j] = ws[j-1];
      if (wn < 4) wn++;
      h = 1'b0;
    end
    ws[0] = b;
  endtask

  task automatic runSeg(input int e, output int misses);
    bit h;
    misses = 0;
    for (int k = 0; k < SLEN; k++) begin
      modelStep(tr[e*SLEN + k], h);
      if (!h) misses++;
    end
  endtask

  task automatic clearWork();
    wn = 0;
    for (int j = 0; j < 4; j++) ws[j] = 0;
  endtask

  task automatic computeModel(input int s);
    int m;
    bit h, changed;
    int rounds;
    clearWork();
    expMiss = 0;
    for (int a = 0; a < s*SLEN; a++) begin
      modelStep(tr[a], h);
      if (!h) expMiss++;
    end
    expHits = s*SLEN - expMiss;
    expBound = 0;
    for (int e = 0; e < s; e++) begin
      clearWork();
      runSeg(e, m);
      expBound += m;
      for (int j = 0; j < 4; j++) fin[e][j] = ws[j];
      finN[e] = wn;
    end
    rounds = 0;
    if (s > 1) begin
      do begin
        changed = 1'b0;
        for (int e = 1; e < s; e++) begin
          for (int j = 0; j < 4; j++) ws[j] = fin[e-1][j];
          wn = finN[e-1];
          runSeg(e, m);
          for (int j = 0; j < 4; j++) nf[e][j] = ws[j];
          nfN[e] = wn;
          if (e < s-1) begin
            if (nfN[e] != finN[e]) changed = 1'b1;
            for (int j = 0; j < 4; j++) if (nf[e][j] != fin[e][j]) changed = 1'b1;
          end
        end
        for (int e = 1; e < s; e++) begin
          for (int j = 0; j < 4; j++) fin[e][j] = nf[e][j];
          finN[e] = nfN[e];
        end
        rounds++;
      end while (changed && rounds < 50);
    end
    expRounds = (rounds > NSEG) ? NSEG : rounds;
  endtask

  task automatic loadAll();
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      loadEn = 1'b1; loadAddr = 6'(a); loadBlk = 8'(tr[a]);
    end
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  // Runs one job and checks it against the model. With poke set, a load and a start are driven mid-run.
  task automatic runAndCheck(input int segIn, input bit poke, input string tag);
    int s = (segIn == 0) ? 1 : ((segIn > NSEG) ? NSEG : segIn);
    int wait_n = 0;
    int h0, m0, r0;
    computeModel(s);
    @(negedge clk);
    segCount = 3'(segIn); start = 1'b1;
    @(negedge clk);
    start = 1'b0; segCount = 3'd3;
    if (poke) begin
      @(negedge clk); @(negedge clk);
      loadEn = 1'b1; loadAddr = 6'd0; loadBlk = 8'd200; start = 1'b1;
      @(negedge clk);
      loadEn = 1'b0; start = 1'b0;
    end
    while (!done && wait_n < 5000) begin
      @(negedge clk);
      wait_n++;
    end
    check("R7", {tag, " done seen"}, int'(done), 1);
    check("R5", {tag, " hits"}, int'(totalHits), expHits);
    check("R5", {tag, " misses"}, int'(totalMisses), expMiss);
    check("R4", {tag, " bound"}, int'(missBound), expBound);
    check("R4", {tag, " bound not below misses"}, int'(missBound >= totalMisses), 1);
    check("R6", {tag, " rounds"}, int'(fixRounds), expRounds);
    h0 = totalHits; m0 = totalMisses; r0 = fixRounds;
    @(negedge clk);
    check("R7", {tag, " done one cycle"}, int'(done), 0);
    repeat (3) @(negedge clk);
    check("R7", {tag, " hits held"}, int'(totalHits), h0);
    check("R7", {tag, " rounds held"}, int'(fixRounds) * 256 + int'(totalMisses), r0 * 256 + m0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R10", "reset hits", int'(totalHits), 0);
    check("R10", "reset misses", int'(totalMisses), 0);
    check("R10", "reset bound", int'(missBound), 0);
    check("R10", "reset done/rounds", int'(done) + int'(fixRounds), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R2 R5: small alphabet so both hits and evictions occur
    for (int a = 0; a < DEPTH; a++) tr[a] = (a*5 + a/3) % 7 + 1;
    loadAll();
    runAndCheck(4, 1'b0, "mixed4 R1 R2");

    // R8: load and start during a run are ignored; rerun shows the trace kept
    runAndCheck(4, 1'b1, "poke R8");
    runAndCheck(4, 1'b0, "rerun R8");
    check("R8", "trace addr0 kept", int'(totalHits), expHits);

    // R9: clamping of segment count
    runAndCheck(0, 1'b0, "seg0 R9");
    check("R9", "seg0 acts as one", int'(totalHits + totalMisses), SLEN);
    runAndCheck(7, 1'b0, "seg7 R9");
    check("R9", "seg7 acts as four", int'(totalHits + totalMisses), DEPTH);

    // R6: state ripples through every segment, maximum rounds
    for (int a = 0; a < DEPTH; a++) tr[a] = (a < SLEN) ? (a % 4) + 1 : 9;
    loadAll();
    runAndCheck(4, 1'b0, "ripple R6");
    check("R6", "ripple needs three rounds", int'(fixRounds), 3);
    check("R2", "ripple exact misses", int'(totalMisses), 5);

    // R3: block zero on an empty stack is a miss
    for (int a = 0; a < DEPTH; a++) tr[a] = 0;
    loadAll();
    runAndCheck(1, 1'b0, "zeros R3");
    check("R3", "zero first ref misses", int'(totalMisses), 1);
    check("R6", "single segment no rounds", int'(fixRounds), 0);

    // R5: two segments, wider alphabet
    for (int a = 0; a < DEPTH; a++) tr[a] = (a*a) % 11 + 20;
    loadAll();
    runAndCheck(2, 1'b0, "squares R5");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule